// File: doc/BRIEF.md
# System Clock Divider Bank

This block takes the output of a phase-locked loop and derives seven divided system clock enables from it. The design lives in one fast clock domain. The loop output and the bypass reference both arrive as single-cycle enable pulses in that domain.

A select input chooses which of the two pulse streams drives the bank. The chosen stream first passes through a programmable post-divider, and then through seven output dividers. Four of the outputs form a locked group: outputs 1 and 6, output 2 and output 4 always keep a 1:2:4 ratio, and software can only rescale them together. Outputs 3, 5 and 7 can each be reprogrammed on their own. An auxiliary output always repeats the bypass reference, whatever the other settings are.

Software writes new ratios through a small write port into shadow registers. A GO command then copies every shadow value into the active dividers at once and restarts all counters together, so the outputs come out phase aligned. Writes that would break the locked group are refused and raise a sticky error flag.

Top module: `sysclk_div_bank`

## Requirements
- R1: After reset the post-divider is /1 and outputs 1 to 7 divide the source pulse stream by 1, 2, 3, 4, 3, 1 and 6. Every output fires on the first source pulse after reset.
- R2: When `bypass` is 1 the source stream is `ref_ce`, otherwise it is `pll_ce`. No output fires in a cycle without a pulse on the selected source.
- R3: A write to address 0 with `wr_data[4:0]`=N sets the post-divider to divide the source stream by N+1. The post-divider's output is what every output divider counts.
- R4: A write to address 3, 5 or 7 sets that output to divide by `wr_data[4:0]`+1. With `wr_data[7]`=1 the output is switched off and never fires.
- R5: A write to address 8 with base B = `wr_data[4:0]` in 0..7 makes outputs 1 and 6 divide by B+1, output 2 by 2(B+1) and output 4 by 4(B+1). Outputs 1 and 6 always fire in the same cycles.
- R6: A write to address 1, 2, 4, 6 or 10 to 15 is refused and changes nothing. So is a write to address 8 with B greater than 7. Each refused write sets `wr_err` from the next cycle, and `wr_err` stays set until reset.
- R7: Shadowed writes (addresses 0, 3, 5, 7 and 8) do not affect the outputs until a GO command is given.
- R8: A write to address 9 is GO. In the GO cycle the outputs still follow the old settings. From the next cycle, all counters restart from zero, and the first selected source pulse fires every enabled output together.
- R9: `busy` is high for exactly M cycles, starting the cycle after GO. M is the largest divide value among the enabled outputs under the new settings. A GO given while busy reloads the count.
- R10: `aux_ce` equals `ref_ce` in every cycle.
- R11: Whenever output 4 fires, outputs 1, 2 and 6 fire in the same cycle. Whenever output 2 fires, output 1 fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_ce | input | 1 | Loop output pulse stream |
| ref_ce | input | 1 | Bypass reference pulse stream |
| bypass | input | 1 | Selects the reference stream as source |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| sys_ce | output | 7 | Divided enables, bit i is output i+1 |
| aux_ce | output | 1 | Copy of the reference stream |
| busy | output | 1 | Realignment window after GO |
| wr_err | output | 1 | Sticky refused-write flag |

## Verification
The GO command and a pulse on the selected source can fall in the same cycle. The bench provokes this by issuing GO together with a source pulse, and also by issuing GO at random points while the pulse streams are random. A behavioural model counts pulses with modulo arithmetic and is compared with the design on every clock. The model expects the old ratios in the GO cycle itself and a common first pulse on every enabled output at the next source pulse. The same model also judges a second GO that lands while `busy` is still counting down.

// File: rtl/sysclk_div_bank.sv
module sysclk_div_bank #(
  parameter int FW = 5,
  parameter bit ALLOW_OFF = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pll_ce,
  input  logic       ref_ce,
  input  logic       bypass,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [6:0] sys_ce,
  output logic       aux_ce,
  output logic       busy,
  output logic       wr_err
);
  localparam int NO = 7;
  localparam logic [FW-1:0] GMAX = FW'((1 << (FW - 2)) - 1);

  function automatic logic [FW-1:0] def_ratio(input int i);
    case (i)
      0: return FW'(0);
      1: return FW'(1);
      2: return FW'(2);
      3: return FW'(3);
      4: return FW'(2);
      5: return FW'(0);
      default: return FW'(5);
    endcase
  endfunction

  logic [FW-1:0] sh_div [NO];
  logic [FW-1:0] act_div [NO];
  logic [FW-1:0] cnt [NO];
  logic [NO-1:0] sh_off, act_off;
  logic [FW-1:0] sh_pd, act_pd, pd_cnt;
  logic [FW:0]   busy_cnt, max_div;
  logic [FW-1:0] base;
  logic src_ce, post_ce, go, grp_ok, prog_sel, bad_wr;

  assign src_ce   = bypass ? ref_ce : pll_ce;
  assign post_ce  = src_ce && (pd_cnt == '0);
  assign aux_ce   = ref_ce;
  assign busy     = busy_cnt != '0;
  assign go       = wr_en && (wr_addr == 4'd9);
  assign base     = wr_data[FW-1:0];
  assign grp_ok   = base <= GMAX;
  assign prog_sel = (wr_addr == 4'd3) || (wr_addr == 4'd5) || (wr_addr == 4'd7);
  assign bad_wr   = wr_en && !((wr_addr == 4'd0) || prog_sel ||
                               ((wr_addr == 4'd8) && grp_ok) || go);

  for (genvar i = 0; i < NO; i++) begin : g_out
    assign sys_ce[i] = post_ce && (cnt[i] == '0) && !act_off[i];
  end

  always_comb begin
    max_div = '0;
    for (int i = 0; i < NO; i++)
      if (!sh_off[i] && ((FW+1)'(sh_div[i]) + (FW+1)'(1)) > max_div)
        max_div = (FW+1)'(sh_div[i]) + (FW+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NO; i++) sh_div[i] <= def_ratio(i);
      sh_off <= '0;
      sh_pd  <= '0;
      wr_err <= 1'b0;
    end else begin
      if (bad_wr) wr_err <= 1'b1;
      if (wr_en) begin
        case (wr_addr)
          4'd0: sh_pd <= base;
          4'd3: begin sh_div[2] <= base; sh_off[2] <= wr_data[7] & ALLOW_OFF; end
          4'd5: begin sh_div[4] <= base; sh_off[4] <= wr_data[7] & ALLOW_OFF; end
          4'd7: begin sh_div[6] <= base; sh_off[6] <= wr_data[7] & ALLOW_OFF; end
          4'd8: if (grp_ok) begin
            sh_div[0] <= base;
            sh_div[5] <= base;
            sh_div[1] <= {base[FW-2:0], 1'b1};
            sh_div[3] <= {base[FW-3:0], 2'b11};
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NO; i++) begin
        act_div[i] <= def_ratio(i);
        cnt[i]     <= '0;
      end
      act_off  <= '0;
      act_pd   <= '0;
      pd_cnt   <= '0;
      busy_cnt <= '0;
    end else if (go) begin
      for (int i = 0; i < NO; i++) begin
        act_div[i] <= sh_div[i];
        cnt[i]     <= '0;
      end
      act_off  <= sh_off;
      act_pd   <= sh_pd;
      pd_cnt   <= '0;
      busy_cnt <= max_div;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (src_ce) pd_cnt <= (pd_cnt == '0) ? act_pd : pd_cnt - 1'b1;
      if (post_ce)
        for (int i = 0; i < NO; i++)
          cnt[i] <= (cnt[i] == '0) ? act_div[i] : cnt[i] - 1'b1;
    end
  end

  p_src_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|sys_ce) |-> (bypass ? ref_ce : pll_ce));
  p_twin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ce[0] == sys_ce[5]);
  p_group_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ce[3] |-> (sys_ce[0] && sys_ce[1] && sys_ce[5]));
  p_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ce[1] |-> sys_ce[0]);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (!(bypass ? ref_ce : pll_ce) || ((sys_ce | act_off) == 7'h7f)));
endmodule

// File: tb/sysclk_div_bank_bench.sv
module sysclk_div_bank_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, pll_ce, ref_ce, bypass, wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [6:0] sys_ce;
  logic aux_ce, busy, wr_err;

  sysclk_div_bank u_sysclk_div_bank (
    .clk(clk), .rst_n(rst_n), .pll_ce(pll_ce), .ref_ce(ref_ce), .bypass(bypass),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sys_ce(sys_ce), .aux_ce(aux_ce), .busy(busy), .wr_err(wr_err));

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";
  bit byp = 0;

  int sh_div[7], act_div[7];
  bit sh_off[7], act_off[7];
  int sh_pd, act_pd, pcnt, qcnt, busy_left;
  bit err;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    sh_div = '{1, 2, 3, 4, 3, 1, 6};
    act_div = sh_div;
    for (int i = 0; i < 7; i++) begin sh_off[i] = 0; act_off[i] = 0; end
    sh_pd = 1; act_pd = 1; pcnt = 0; qcnt = 0; busy_left = 0; err = 0;
  endtask

  task automatic cycle(bit p, bit r, bit b, bit we, logic [3:0] a, logic [7:0] d);
    bit src, post, go;
    int mx;
    pll_ce = p; ref_ce = r; bypass = b; wr_en = we; wr_addr = a; wr_data = d;
    #1;
    src = b ? r : p;
    post = src && (pcnt % act_pd == 0);
    for (int i = 0; i < 7; i++)
      chk(tag, $sformatf("out%0d", i + 1), int'(sys_ce[i]),
          int'(post && (qcnt % act_div[i] == 0) && !act_off[i]));
    chk("R10", "aux_ce", int'(aux_ce), int'(r));
    chk("R9", "busy", int'(busy), int'(busy_left > 0));
    chk("R6", "wr_err", int'(wr_err), int'(err));
    if (sys_ce[3]) chk("R11", "group on out4", int'(sys_ce[0] & sys_ce[1] & sys_ce[5]), 1);
    if (sys_ce[1]) chk("R11", "out1 on out2", int'(sys_ce[0]), 1);
    @(posedge clk);
    go = we && a == 4'd9;
    mx = 0;
    for (int i = 0; i < 7; i++) if (!sh_off[i] && sh_div[i] > mx) mx = sh_div[i];
    if (go) begin
      act_div = sh_div; act_off = sh_off; act_pd = sh_pd;
      pcnt = 0; qcnt = 0; busy_left = mx;
    end else begin
      if (busy_left > 0) busy_left--;
      if (src) pcnt++;
      if (post) qcnt++;
    end
    if (we) begin
      case (a)
        4'd0: sh_pd = int'(d[4:0]) + 1;
        4'd3, 4'd5, 4'd7: begin sh_div[a-1] = int'(d[4:0]) + 1; sh_off[a-1] = d[7]; end
        4'd8: if (d[4:0] <= 7) begin
          sh_div[0] = int'(d[4:0]) + 1; sh_div[5] = sh_div[0];
          sh_div[1] = 2 * sh_div[0]; sh_div[3] = 4 * sh_div[0];
        end else err = 1;
        4'd9: ;
        default: err = 1;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic run(int n, int mode);
    for (int k = 0; k < n; k++)
      case (mode)
        0: cycle(1'b1, 1'($urandom_range(1, 0)), byp, 1'b0, 4'd0, 8'd0);
        default: cycle(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), byp, 1'b0, 4'd0, 8'd0);
      endcase
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    cycle(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), byp, 1'b1, a, d);
  endtask

  initial begin
    rst_n = 0; pll_ce = 0; ref_ce = 0; bypass = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'd0);
    run(40, 0); run(40, 1);
    tag = "R2"; byp = 1; run(60, 1); byp = 0; run(20, 1);
    tag = "R7"; wr(3, 8'd4); wr(8, 8'd1); wr(0, 8'd1); run(40, 0);
    tag = "R8"; cycle(1'b1, 1'b0, 1'b0, 1'b1, 4'd9, 8'd0); run(60, 1);
    cycle(1'b0, 1'b1, 1'b0, 1'b1, 4'd9, 8'd0); run(30, 0);
    tag = "R3"; wr(0, 8'd2); wr(9, 8'd0); run(60, 0); run(40, 1);
    tag = "R4"; wr(0, 8'd0); wr(5, 8'h80); wr(7, 8'd9); wr(3, 8'd0); wr(9, 8'd0); run(80, 1);
    tag = "R6"; wr(2, 8'd3); wr(8, 8'd8); wr(12, 8'd0); wr(1, 8'd0); wr(6, 8'd2);
    run(20, 0); wr(9, 8'd0); run(40, 0);
    tag = "R9"; wr(8, 8'd7); wr(9, 8'd0); run(10, 0); wr(9, 8'd0); run(60, 0);
    tag = "R5"; byp = 1; wr(8, 8'd2); wr(5, 8'd1); wr(9, 8'd0); run(120, 1);
    byp = 0; wr(8, 8'd0); wr(9, 8'd0); run(40, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule